// File: doc/BRIEF.md
# Multichannel Debug FIFO Peripheral

This block is a memory-mapped link between a CPU and a debug probe. Software writes 32-bit words into a shared transmit FIFO. The transmit register address picks one of 16 logical channels, and that channel number travels with the word. The probe side drains the transmit FIFO with a valid/ready stream, and each entry it receives is a channel/data pair.

In the other direction, the probe pushes channel-tagged words into a shared receive FIFO, also with valid/ready. Software reads the status register to learn the occupancy and the channel of the oldest entry, then reads the receive register to pop that entry.

A single level interrupt combines a TX condition and an RX condition. Each condition is selected by its own 2-bit threshold mode in the configuration register. Both FIFO depths are parameters and read back as read-only fields.

Top module: `mdbg_fifo`

## Requirements
- R1: After reset, the status register (0x10) reads 0x0000000A, meaning both FIFOs are empty with zero counts. The access register (0x00) reads 0 and `irq_o` is low.
- R2: The configuration register (0x08) reads TX depth in bits 15:8 and RX depth in bits 7:0. Writes to those bits have no effect. Bits 19:18 (TX mode) and 17:16 (RX mode) are writable and read back. All other bits read 0.
- R3: A bus write to 0x20 + 8*n (n = 0..15) pushes the write data into the TX FIFO tagged with channel n. The probe side sees entries in write order on `tx_chan_o`/`tx_data_o` while `tx_valid_o` is high. Each entry is consumed on a cycle where `tx_ready_i` is also high.
- R4: A transmit write while the TX FIFO holds its full depth is dropped and sets bit 0 of the access register (0x00). That bit stays set until a write to 0x00 with bit 0 = 1. A write with bit 0 = 0 leaves it set.
- R5: A probe entry is accepted on a cycle where `rx_valid_i` and `rx_ready_o` are both high. `rx_ready_o` is low while the RX FIFO is full, and a word offered then is not stored.
- R6: The status register layout is:
  - bits 31:24: TX count
  - bits 23:16: RX count
  - bits 7:4: channel of the oldest RX entry
  - bit 3: RX empty
  - bit 2: RX full
  - bit 1: TX empty
  - bit 0: TX full
  - all other bits: 0
- R7: A read of 0x18 returns the oldest RX word and removes it. A read of 0x18 while the RX FIFO is empty returns 0 and changes nothing.
- R8: TX mode 0 never raises the interrupt. Mode 1 raises it when TX is empty, mode 2 when TX is not full, and mode 3 when 4 × TX count ≤ TX depth.
- R9: RX mode 0 never raises the interrupt. Mode 1 raises it when RX is full, mode 2 when RX is not empty, and mode 3 when 4 × RX count ≥ 3 × RX depth.
- R10: `irq_o` is the OR of the TX and RX conditions. It is registered, so it reflects configuration and FIFO state one clock edge after they change.
- R11: Each FIFO count changes by at most one per cycle and never exceeds its depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (pops RX on 0x18) |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| tx_valid_o | output | 1 | TX FIFO holds an entry for the probe |
| tx_ready_i | input | 1 | Probe takes the TX head entry |
| tx_chan_o | output | 4 | Channel of the TX head entry |
| tx_data_o | output | 32 | Data of the TX head entry |
| rx_valid_i | input | 1 | Probe offers an RX entry |
| rx_ready_o | output | 1 | RX FIFO has room |
| rx_chan_i | input | 4 | Channel of the offered RX entry |
| rx_data_i | input | 32 | Data of the offered RX entry |
| irq_o | output | 1 | Level interrupt |

## Verification
The bound checker watches several rules on every cycle:
- backpressure on `rx_ready_o` whenever the RX FIFO is full;
- `tx_valid_o` agreeing with the TX count;
- the overflow bit staying set until it is cleared, and being set by a write into a full TX FIFO;
- both counts staying bounded and moving by at most one step per cycle;
- the interrupt staying low one cycle after both modes are off.

Other behaviour is only visible from the directed scenarios. These cover channel tagging by address, the ordering of data through each FIFO, and the exact status and configuration bit layouts. They also cover the value read from an empty receive register, every threshold mode's trip point at its quarter boundaries, and the one-cycle interrupt latency.

// File: rtl/mdbg_pkg.sv
`timescale 1ns/1ps
package mdbg_pkg;
  localparam int DW       = 32;
  localparam int CHAN_W   = 4;
  localparam int NUM_CHAN = 1 << CHAN_W;

  localparam logic [7:0] OFS_ACCESS = 8'h00;
  localparam logic [7:0] OFS_CONFIG = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_RXDATA = 8'h18;
  localparam logic [7:0] OFS_TXBASE = 8'h20;

  typedef enum logic [1:0] {TXM_OFF, TXM_EMPTY, TXM_NOT_FULL, TXM_LOW} tx_mode_e;
  typedef enum logic [1:0] {RXM_OFF, RXM_FULL, RXM_NOT_EMPTY, RXM_HIGH} rx_mode_e;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic [DW-1:0]     data;
  } entry_t;
endpackage

// File: rtl/mdbg_sfifo.sv
`timescale 1ns/1ps
module mdbg_sfifo #(
  parameter int W     = 36,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mdbg_irq.sv
`timescale 1ns/1ps
module mdbg_irq
  import mdbg_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  tx_mode_e       tx_mode_i,
  input  rx_mode_e       rx_mode_i,
  input  logic [TCW-1:0] tx_cnt_i,
  input  logic [RCW-1:0] rx_cnt_i,
  output logic           irq_o
);
  logic tx_hit, rx_hit, irq_q;
  logic [31:0] tx_x4, rx_x4;

  assign tx_x4 = 32'(tx_cnt_i) << 2;
  assign rx_x4 = 32'(rx_cnt_i) << 2;

  always_comb begin
    unique case (tx_mode_i)
      TXM_EMPTY:    tx_hit = (tx_cnt_i == '0);
      TXM_NOT_FULL: tx_hit = (tx_cnt_i != TCW'(TX_DEPTH));
      TXM_LOW:      tx_hit = (tx_x4 <= 32'(TX_DEPTH));
      default:      tx_hit = 1'b0;
    endcase
    unique case (rx_mode_i)
      RXM_FULL:      rx_hit = (rx_cnt_i == RCW'(RX_DEPTH));
      RXM_NOT_EMPTY: rx_hit = (rx_cnt_i != '0);
      RXM_HIGH:      rx_hit = (rx_x4 >= 32'(3 * RX_DEPTH));
      default:       rx_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= tx_hit | rx_hit;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mdbg_fifo.sv
`timescale 1ns/1ps
module mdbg_fifo
  import mdbg_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [CHAN_W-1:0] tx_chan_o,
  output logic [DW-1:0]     tx_data_o,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [CHAN_W-1:0] rx_chan_i,
  input  logic [DW-1:0]     rx_data_i,
  output logic              irq_o
);
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);
  localparam int EW  = $bits(entry_t);

  logic [4:0]     tx_slot;
  logic           tx_hit, rx_pop, ovf_q, ovf_clr;
  tx_mode_e       tx_mode_q;
  rx_mode_e       rx_mode_q;
  entry_t         tx_in, tx_head, rx_in, rx_head;
  logic [TCW-1:0] tx_cnt;
  logic [RCW-1:0] rx_cnt;
  logic           tx_full, tx_empty, rx_full, rx_empty;

  // Transmit window: one 8-byte slot per channel starting at the base offset
  assign tx_slot = bus_addr_i[7:3] - OFS_TXBASE[7:3];
  assign tx_hit  = bus_we_i && (bus_addr_i[2:0] == 3'd0) && (tx_slot < 5'(NUM_CHAN));
  assign tx_in   = '{chan: tx_slot[CHAN_W-1:0], data: bus_wdata_i};
  assign rx_in   = '{chan: rx_chan_i, data: rx_data_i};
  assign rx_pop  = bus_re_i && (bus_addr_i == OFS_RXDATA);
  assign ovf_clr = bus_we_i && (bus_addr_i == OFS_ACCESS) && bus_wdata_i[0];

  mdbg_sfifo #(.W(EW), .DEPTH(TX_DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i(tx_hit), .data_i(tx_in),
    .pop_i(tx_ready_i), .data_o(tx_head),
    .cnt_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  mdbg_sfifo #(.W(EW), .DEPTH(RX_DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i(rx_valid_i), .data_i(rx_in),
    .pop_i(rx_pop), .data_o(rx_head),
    .cnt_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  assign tx_valid_o = !tx_empty;
  assign tx_chan_o  = tx_head.chan;
  assign tx_data_o  = tx_head.data;
  assign rx_ready_o = !rx_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q     <= 1'b0;
      tx_mode_q <= TXM_OFF;
      rx_mode_q <= RXM_OFF;
    end else begin
      ovf_q <= (tx_hit && tx_full) || (ovf_q && !ovf_clr);
      if (bus_we_i && bus_addr_i == OFS_CONFIG) begin
        tx_mode_q <= tx_mode_e'(bus_wdata_i[19:18]);
        rx_mode_q <= rx_mode_e'(bus_wdata_i[17:16]);
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFS_ACCESS: bus_rdata_o[0] = ovf_q;
      OFS_CONFIG: bus_rdata_o = {12'd0, tx_mode_q, rx_mode_q, 8'(TX_DEPTH), 8'(RX_DEPTH)};
      OFS_STATUS: bus_rdata_o = {8'(tx_cnt), 8'(rx_cnt), 8'd0,
                                 rx_empty ? 4'd0 : rx_head.chan,
                                 rx_empty, rx_full, tx_empty, tx_full};
      OFS_RXDATA: bus_rdata_o = rx_empty ? '0 : rx_head.data;
      default:    bus_rdata_o = '0;
    endcase
  end

  mdbg_irq #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_irq (
    .clk_i, .rst_ni,
    .tx_mode_i(tx_mode_q), .rx_mode_i(rx_mode_q),
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
    .irq_o
  );
endmodule

// File: rtl/mdbg_fifo_chk.sv
`timescale 1ns/1ps
module mdbg_fifo_chk #(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           bus_we_i,
  input logic [7:0]     bus_addr_i,
  input logic [31:0]    bus_wdata_i,
  input logic           tx_valid_o,
  input logic           rx_ready_o,
  input logic           irq_o,
  input logic [TCW-1:0] tx_cnt,
  input logic [RCW-1:0] rx_cnt,
  input logic           ovf_q,
  input logic [1:0]     tx_mode_q,
  input logic [1:0]     rx_mode_q
);
  AST_RX_BACKPRESSURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt == RCW'(RX_DEPTH)) |-> !rx_ready_o); // R5

  AST_TX_VALID_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o == (tx_cnt != '0)); // R3

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(bus_we_i && bus_addr_i == 8'h00 && bus_wdata_i[0])) |=> ovf_q); // R4

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt == TCW'(TX_DEPTH) && bus_we_i && bus_addr_i == 8'h20) |=> ovf_q); // R4

  AST_TX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= TCW'(TX_DEPTH)); // R11

  AST_RX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= RCW'(RX_DEPTH)); // R11

  AST_TX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (tx_cnt == $past(tx_cnt) || tx_cnt == $past(tx_cnt) + 1'b1
              || tx_cnt + 1'b1 == $past(tx_cnt))); // R11

  AST_RX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rx_cnt == $past(rx_cnt) || rx_cnt == $past(rx_cnt) + 1'b1
              || rx_cnt + 1'b1 == $past(rx_cnt))); // R11

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_mode_q == 2'd0 && rx_mode_q == 2'd0) |=> !irq_o); // R10
endmodule

bind mdbg_fifo mdbg_fifo_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .tx_valid_o(tx_valid_o), .rx_ready_o(rx_ready_o),
  .irq_o(irq_o), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ovf_q(ovf_q),
  .tx_mode_q(tx_mode_q), .rx_mode_q(rx_mode_q)
);

// File: tb/sim_mdbg_fifo.sv
`timescale 1ns/1ps
module sim_mdbg_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [3:0]  tx_chan;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [3:0]  rx_chan = '0;
  logic [31:0] rx_data = '0;
  logic        irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  mdbg_fifo u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .tx_chan_o(tx_chan), .tx_data_o(tx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .rx_chan_i(rx_chan), .rx_data_i(rx_data), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic probe_push(input logic [3:0] c, input logic [31:0] d, output logic acc);
    @(negedge clk); rx_valid = 1'b1; rx_chan = c; rx_data = d; #1 acc = rx_ready;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic probe_pop(output logic v, output logic [3:0] c, output logic [31:0] d);
    @(negedge clk); tx_ready = 1'b1; #1 v = tx_valid; c = tx_chan; d = tx_data;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    @(negedge clk);
    chk(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    peek(8'h10, d); chk("R1 status", d, 32'h0000_000A);
    peek(8'h00, d); chk("R1 access", d, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    peek(8'h08, d); chk("R2 cfg reset", d, 32'h0000_1010);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    bus_wr(8'h08, 32'hFFFF_FFFF);
    peek(8'h08, d); chk("R2 cfg rw", d, 32'h000F_1010);
    chk("R8 mode3 empty irq", {31'd0, irq}, 32'd1);
    bus_wr(8'h08, 32'h0);
    irq_chk("R10 irq off", 1'b0);
  endtask

  task automatic t_tx();
    logic [31:0] d; logic v; logic [3:0] c;
    bus_wr(8'h20, 32'h1111_0000);
    bus_wr(8'h98, 32'h2222_000F);
    bus_wr(8'h48, 32'h3333_0005);
    peek(8'h10, d); chk("R6 status tx3", d, 32'h0300_0008);
    probe_pop(v, c, d); chk("R3 pop0", {v, 23'd0, c, d[3:0]}, {1'b1, 23'd0, 4'd0, 4'h0}); chk("R3 data0", d, 32'h1111_0000);
    probe_pop(v, c, d); chk("R3 chan15", {28'd0, c}, 32'd15); chk("R3 data1", d, 32'h2222_000F);
    probe_pop(v, c, d); chk("R3 chan5", {28'd0, c}, 32'd5); chk("R3 data2", d, 32'h3333_0005);
    probe_pop(v, c, d); chk("R3 empty valid", {31'd0, v}, 32'd0);
  endtask

  task automatic t_ovf();
    logic [31:0] d; logic v; logic [3:0] c;
    for (int i = 0; i < 16; i++) bus_wr(8'h38, 32'hC000_0000 + i);
    peek(8'h10, d); chk("R6 status txfull", d, 32'h1000_0009);
    peek(8'h00, d); chk("R4 no ovf yet", d, 32'h0);
    bus_wr(8'h38, 32'hDEAD_BEEF);
    peek(8'h00, d); chk("R4 ovf set", d, 32'h1);
    peek(8'h10, d); chk("R4 count held", d, 32'h1000_0009);
    for (int i = 0; i < 16; i++) begin
      probe_pop(v, c, d);
      chk("R4 drain data", d, 32'hC000_0000 + i);
      chk("R3 drain chan", {28'd0, c}, 32'd3);
    end
    probe_pop(v, c, d); chk("R4 dropped absent", {31'd0, v}, 32'd0);
    bus_wr(8'h00, 32'h0);
    peek(8'h00, d); chk("R4 w0 keeps", d, 32'h1);
    bus_wr(8'h00, 32'h1);
    peek(8'h00, d); chk("R4 w1 clears", d, 32'h0);
  endtask

  task automatic t_rx();
    logic [31:0] d; logic acc;
    probe_push(4'd7, 32'hAAAA_0007, acc); chk("R5 acc", {31'd0, acc}, 32'd1);
    probe_push(4'd2, 32'hBBBB_0002, acc);
    probe_push(4'd9, 32'hCCCC_0009, acc);
    peek(8'h10, d); chk("R6 status rx3", d, 32'h0003_0072);
    bus_rd(8'h18, d); chk("R7 rd0", d, 32'hAAAA_0007);
    peek(8'h10, d); chk("R6 head chan2", d, 32'h0002_0022);
    bus_rd(8'h18, d); chk("R7 rd1", d, 32'hBBBB_0002);
    bus_rd(8'h18, d); chk("R7 rd2", d, 32'hCCCC_0009);
    bus_rd(8'h18, d); chk("R7 empty rd", d, 32'h0);
    peek(8'h10, d); chk("R7 empty status", d, 32'h0000_000A);
  endtask

  task automatic t_rx_full();
    logic [31:0] d; logic acc;
    for (int i = 0; i < 16; i++) probe_push(4'(i), 32'hA000_0000 + i, acc);
    peek(8'h10, d); chk("R6 status rxfull", d, 32'h0010_0006);
    chk("R5 ready low", {31'd0, rx_ready}, 32'd0);
    probe_push(4'd5, 32'h5555_5555, acc); chk("R5 refused", {31'd0, acc}, 32'd0);
    for (int i = 0; i < 16; i++) begin
      bus_rd(8'h18, d); chk("R5 rx order", d, 32'hA000_0000 + i);
    end
    peek(8'h10, d); chk("R5 extra not stored", d, 32'h0000_000A);
  endtask

  task automatic t_irq_tx();
    logic v; logic [3:0] c; logic [31:0] d;
    bus_wr(8'h08, 32'h0004_0000);
    chk("R10 latency", {31'd0, irq}, 32'd0);
    irq_chk("R8 empty mode", 1'b1);
    bus_wr(8'h20, 32'h1);
    irq_chk("R8 empty mode off", 1'b0);
    bus_wr(8'h08, 32'h000C_0000);
    irq_chk("R8 low mode 1", 1'b1);
    for (int i = 0; i < 3; i++) bus_wr(8'h20, 32'h1);
    irq_chk("R8 low mode 4", 1'b1);
    bus_wr(8'h20, 32'h1);
    irq_chk("R8 low mode 5", 1'b0);
    bus_wr(8'h08, 32'h0008_0000);
    irq_chk("R8 notfull mode", 1'b1);
    for (int i = 0; i < 11; i++) bus_wr(8'h20, 32'h1);
    irq_chk("R8 notfull at full", 1'b0);
    for (int i = 0; i < 16; i++) probe_pop(v, c, d);
    bus_wr(8'h08, 32'h0);
  endtask

  task automatic t_irq_rx();
    logic acc; logic [31:0] d;
    bus_wr(8'h08, 32'h0001_0000);
    irq_chk("R9 full mode empty", 1'b0);
    for (int i = 0; i < 16; i++) probe_push(4'd1, 32'h0, acc);
    irq_chk("R9 full mode full", 1'b1);
    bus_wr(8'h08, 32'h0003_0000);
    irq_chk("R9 high 16", 1'b1);
    for (int i = 0; i < 4; i++) bus_rd(8'h18, d);
    irq_chk("R9 high 12", 1'b1);
    bus_rd(8'h18, d);
    irq_chk("R9 high 11", 1'b0);
    bus_wr(8'h08, 32'h0002_0000);
    irq_chk("R9 notempty", 1'b1);
    for (int i = 0; i < 11; i++) bus_rd(8'h18, d);
    irq_chk("R9 notempty drained", 1'b0);
    bus_wr(8'h08, 32'h0);
  endtask

  task automatic t_irq_or();
    logic acc; logic v; logic [3:0] c; logic [31:0] d;
    bus_wr(8'h08, 32'h0006_0000);
    irq_chk("R10 or tx only", 1'b1);
    bus_wr(8'h20, 32'h9);
    probe_push(4'd0, 32'h9, acc);
    irq_chk("R10 or rx only", 1'b1);
    bus_rd(8'h18, d);
    irq_chk("R10 or none", 1'b0);
    probe_pop(v, c, d);
    irq_chk("R10 or tx back", 1'b1);
    bus_wr(8'h08, 32'h0);
    irq_chk("R10 disabled", 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg();
    t_tx();
    t_ovf();
    t_rx();
    t_rx_full();
    t_irq_tx();
    t_irq_rx();
    t_irq_or();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule